// File: doc/BRIEF.md
# Clock-Crossing Bus-to-Register Bridge

This bridge sits between a memory-mapped CPU slave port and a simple 32-bit register bus that runs on an unrelated user clock. Every CPU access first passes through an address decoder. Two address windows lead straight to a pair of buffer RAM ports. Those ports stay in the CPU clock, and accesses to them finish with no wait state. Every other address is packed into a command bundle. That bundle is carried to the user clock with a toggle handshake and played out there as a one-cycle write strobe or a read request. A read request is answered by a read-valid strobe that carries the data.

Back-pressure on the CPU side uses only the wait-request signal. The master holds its command steady while wait is high, and the command is taken in the cycle where wait is low. Buffer accesses are never held off. A forwarded access holds wait high until the handshake has completed. For a write, that means the user side has issued its strobe. For a read, it means the returned word has arrived back in the CPU domain. Only one forwarded access can be in flight at a time. Buffer read data comes back with the read-data-valid strobe a fixed number of cycles after acceptance. Forwarded read data comes back in the same cycle that the read is accepted.

Top module: `mm_reg_bridge`

## Requirements
- R1: Reset: after either reset, cpu_wait and cpu_rvalid are low, reg_wr_en and reg_rd_req are low, and any pending crossing is dropped. A later access then completes normally.
- R2: An access is routed to a buffer when CPU word address bits [13:9] equal 5'b00001 (buffer 0) or 5'b00010 (buffer 1). The buffer is addressed by bits [8:0], only one buffer strobe is high at a time, and such an access never reaches the register bus.
- R3: Every other address is forwarded. reg_addr carries the full 14-bit CPU word address.
- R4: A forwarded write produces exactly one single-cycle reg_wr_en, with reg_wdata and reg_be valid in that cycle. reg_be bit n qualifies data bits [8n+7:8n].
- R5: A forwarded access keeps cpu_wait high from its first cycle until the handshake completes. For a read, completion means the data is back in the CPU clock.
- R6: A buffer access made while nothing is forwarded is accepted with zero wait cycles. Buffer read data returns with cpu_rvalid exactly BUF_RD_LAT cycles after acceptance.
- R7: A forwarded read produces a single-cycle reg_rd_req. The word presented with reg_rd_valid is returned on cpu_rdata, with cpu_rvalid high, in the cycle in which the read is accepted.
- R8: cpu_rvalid is never raised for a write. Every cpu_rvalid matches an accepted read.
- R9: At most one forwarded transaction is outstanding, and the user side never raises reg_wr_en and reg_rd_req together.
- R10: reg_addr, reg_wdata and reg_be stay stable in the user clock cycle that follows a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU-side clock |
| cpu_rst_n | input | 1 | CPU-side asynchronous reset, active low |
| cpu_addr | input | 14 | CPU word address |
| cpu_wr | input | 1 | CPU write command |
| cpu_rd | input | 1 | CPU read command |
| cpu_wdata | input | 32 | CPU write data |
| cpu_be | input | 4 | CPU byte enables |
| cpu_rdata | output | 32 | Read data to CPU |
| cpu_rvalid | output | 1 | Read data valid |
| cpu_wait | output | 1 | Wait request, holds the command |
| buf_wr | output | 2 | Buffer write strobes, one per buffer |
| buf_rd | output | 2 | Buffer read strobes, one per buffer |
| buf_addr | output | 9 | Buffer word address |
| buf_wdata | output | 32 | Buffer write data |
| buf_be | output | 4 | Buffer byte enables |
| buf_rdata0 | input | 32 | Buffer 0 read data, BUF_RD_LAT latency |
| buf_rdata1 | input | 32 | Buffer 1 read data, BUF_RD_LAT latency |
| usr_clk | input | 1 | User-side clock |
| usr_rst_n | input | 1 | User-side asynchronous reset, active low |
| reg_wr_en | output | 1 | Register write strobe |
| reg_rd_req | output | 1 | Register read request |
| reg_addr | output | 14 | Register word address |
| reg_wdata | output | 32 | Register write data |
| reg_be | output | 4 | Register byte enables |
| reg_rd_valid | input | 1 | Register read data valid |
| reg_rd_data | input | 32 | Register read data |

## Verification
The bench aims at the points where the two paths meet. It checks the edges of the two buffer windows against neighbouring forwarded addresses, so a decoder that compared the wrong bits would send buffer words onto the register bus and the strobe counts would be wrong. It checks a partial byte-enable write, where a design that ignored or swapped the enables returns a wrongly merged word. It checks read latency on both paths, where a wrong pipeline depth or a premature wait release returns stale data or the wrong cycle count. It also drops both resets in the middle of a forwarded read, where leftover toggle state would either hang the next access or replay the old one.

// File: rtl/mrb_pkg.sv
package mrb_pkg;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int ADDR_W = 14;
  localparam int TAG_W  = 5;
  localparam int WIN_AW = ADDR_W - TAG_W;
  localparam int N_BUF  = 2;

  typedef struct packed {
    logic              is_rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [BE_W-1:0]   be;
  } fwd_cmd_t;

  typedef enum logic [1:0] {C_IDLE, C_BUSY, C_DONE} cpu_st_t;
  typedef enum logic {U_IDLE, U_WAIT} usr_st_t;
endpackage

// File: rtl/mrb_toggle_sync.sv
module mrb_toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic change_o
);
  // STAGES synchronizer flops plus one history flop for change detection
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], tgl_in};
  end

  assign change_o = sh[STAGES] ^ sh[STAGES-1];
endmodule

// File: rtl/mrb_addr_decode.sv
module mrb_addr_decode import mrb_pkg::*; #(
  parameter logic [TAG_W-1:0] WIN0_TAG = 5'd1,
  parameter logic [TAG_W-1:0] WIN1_TAG = 5'd2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N_BUF-1:0]  hit,
  output logic [WIN_AW-1:0] win_addr
);
  localparam logic [N_BUF*TAG_W-1:0] TAGS = {WIN1_TAG, WIN0_TAG};
  logic [TAG_W-1:0] tag;

  assign tag      = addr[ADDR_W-1 -: TAG_W];
  assign win_addr = addr[WIN_AW-1:0];

  for (genvar i = 0; i < N_BUF; i++) begin : g_win
    assign hit[i] = (tag == TAGS[i*TAG_W +: TAG_W]);
  end
endmodule

// File: rtl/mrb_cpu_side.sv
module mrb_cpu_side import mrb_pkg::*; #(
  parameter int BUF_RD_LAT  = 2,
  parameter int SYNC_STAGES = 2,
  parameter logic [TAG_W-1:0] WIN0_TAG = 5'd1,
  parameter logic [TAG_W-1:0] WIN1_TAG = 5'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [BE_W-1:0]   cpu_be,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rvalid,
  output logic              cpu_wait,
  output logic [N_BUF-1:0]  buf_wr,
  output logic [N_BUF-1:0]  buf_rd,
  output logic [WIN_AW-1:0] buf_addr,
  output logic [DATA_W-1:0] buf_wdata,
  output logic [BE_W-1:0]   buf_be,
  input  logic [DATA_W-1:0] buf_rdata0,
  input  logic [DATA_W-1:0] buf_rdata1,
  output fwd_cmd_t          cmd_o,
  output logic              req_tgl_o,
  input  logic              ack_tgl_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              fwd_busy_o
);
  cpu_st_t            st;
  fwd_cmd_t           cmd_q;
  logic               req_tgl;
  logic [DATA_W-1:0]  rdata_q;
  logic               ack_seen;
  logic [N_BUF-1:0]   hit;
  logic               any_cmd, buf_acc, launch, pipe_busy, buf_rd_go;
  logic [BUF_RD_LAT-1:0] pv, ps;

  mrb_addr_decode #(.WIN0_TAG(WIN0_TAG), .WIN1_TAG(WIN1_TAG)) u_dec (
    .addr(cpu_addr), .hit(hit), .win_addr(buf_addr)
  );

  mrb_toggle_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .tgl_in(ack_tgl_i), .change_o(ack_seen)
  );

  assign any_cmd   = cpu_wr | cpu_rd;
  assign buf_acc   = any_cmd && (|hit) && (st == C_IDLE);
  assign pipe_busy = |pv;
  assign launch    = any_cmd && !(|hit) && (st == C_IDLE) && !pipe_busy;
  assign buf_rd_go = cpu_rd && buf_acc;

  assign buf_wr    = {N_BUF{cpu_wr && buf_acc}} & hit;
  assign buf_rd    = {N_BUF{buf_rd_go}} & hit;
  assign buf_wdata = cpu_wdata;
  assign buf_be    = cpu_be;

  // forwarded-command state machine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= C_IDLE;
      cmd_q   <= '0;
      req_tgl <= 1'b0;
      rdata_q <= '0;
    end else begin
      unique case (st)
        C_IDLE: if (launch) begin
          cmd_q   <= '{is_rd: cpu_rd, addr: cpu_addr, wdata: cpu_wdata, be: cpu_be};
          req_tgl <= ~req_tgl;
          st      <= C_BUSY;
        end
        C_BUSY: if (ack_seen) begin
          rdata_q <= rsp_data_i;
          st      <= C_DONE;
        end
        C_DONE:  st <= C_IDLE;
        default: st <= C_IDLE;
      endcase
    end
  end

  // buffer read-return pipeline, depth chosen by BUF_RD_LAT
  if (BUF_RD_LAT == 1) begin : g_lat1
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pv <= '0;
        ps <= '0;
      end else begin
        pv <= buf_rd_go;
        ps <= hit[1];
      end
    end
  end else begin : g_latn
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pv <= '0;
        ps <= '0;
      end else begin
        pv <= {pv[BUF_RD_LAT-2:0], buf_rd_go};
        ps <= {ps[BUF_RD_LAT-2:0], hit[1]};
      end
    end
  end

  assign cpu_wait   = any_cmd && !(buf_acc || (st == C_DONE));
  assign cpu_rvalid = pv[BUF_RD_LAT-1] || ((st == C_DONE) && cmd_q.is_rd);
  assign cpu_rdata  = (st == C_DONE) ? rdata_q :
                      (ps[BUF_RD_LAT-1] ? buf_rdata1 : buf_rdata0);

  assign cmd_o      = cmd_q;
  assign req_tgl_o  = req_tgl;
  assign fwd_busy_o = (st != C_IDLE);
endmodule

// File: rtl/mrb_usr_side.sv
module mrb_usr_side import mrb_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_tgl_i,
  input  fwd_cmd_t          cmd_i,
  output logic              reg_wr_en,
  output logic              reg_rd_req,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic [BE_W-1:0]   reg_be,
  input  logic              reg_rd_valid,
  input  logic [DATA_W-1:0] reg_rd_data,
  output logic              ack_tgl_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  usr_st_t st;
  logic    req_seen;
  logic    ack_tgl;

  mrb_toggle_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .tgl_in(req_tgl_i), .change_o(req_seen)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= U_IDLE;
      reg_wr_en  <= 1'b0;
      reg_rd_req <= 1'b0;
      ack_tgl    <= 1'b0;
      rsp_data_o <= '0;
    end else begin
      reg_wr_en  <= 1'b0;
      reg_rd_req <= 1'b0;
      unique case (st)
        U_IDLE: if (req_seen) begin
          if (cmd_i.is_rd) begin
            reg_rd_req <= 1'b1;
            st         <= U_WAIT;
          end else begin
            reg_wr_en <= 1'b1;
            ack_tgl   <= ~ack_tgl;
          end
        end
        U_WAIT: if (reg_rd_valid) begin
          rsp_data_o <= reg_rd_data;
          ack_tgl    <= ~ack_tgl;
          st         <= U_IDLE;
        end
        default: st <= U_IDLE;
      endcase
    end
  end

  // bundle is held by the CPU side until the acknowledge returns
  assign reg_addr  = cmd_i.addr;
  assign reg_wdata = cmd_i.wdata;
  assign reg_be    = cmd_i.be;
  assign ack_tgl_o = ack_tgl;
endmodule

// File: rtl/mm_reg_bridge.sv
module mm_reg_bridge import mrb_pkg::*; #(
  parameter int BUF_RD_LAT  = 2,
  parameter int SYNC_STAGES = 2,
  parameter logic [TAG_W-1:0] WIN0_TAG = 5'd1,
  parameter logic [TAG_W-1:0] WIN1_TAG = 5'd2
) (
  input  logic              cpu_clk,
  input  logic              cpu_rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [BE_W-1:0]   cpu_be,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rvalid,
  output logic              cpu_wait,
  output logic [N_BUF-1:0]  buf_wr,
  output logic [N_BUF-1:0]  buf_rd,
  output logic [WIN_AW-1:0] buf_addr,
  output logic [DATA_W-1:0] buf_wdata,
  output logic [BE_W-1:0]   buf_be,
  input  logic [DATA_W-1:0] buf_rdata0,
  input  logic [DATA_W-1:0] buf_rdata1,
  input  logic              usr_clk,
  input  logic              usr_rst_n,
  output logic              reg_wr_en,
  output logic              reg_rd_req,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic [BE_W-1:0]   reg_be,
  input  logic              reg_rd_valid,
  input  logic [DATA_W-1:0] reg_rd_data
);
  fwd_cmd_t          cmd;
  logic              req_tgl, ack_tgl, fwd_busy;
  logic [DATA_W-1:0] rsp_data;

  mrb_cpu_side #(
    .BUF_RD_LAT(BUF_RD_LAT), .SYNC_STAGES(SYNC_STAGES),
    .WIN0_TAG(WIN0_TAG), .WIN1_TAG(WIN1_TAG)
  ) u_cpu (
    .clk(cpu_clk), .rst_n(cpu_rst_n),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
    .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid), .cpu_wait(cpu_wait),
    .buf_wr(buf_wr), .buf_rd(buf_rd), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .buf_be(buf_be),
    .buf_rdata0(buf_rdata0), .buf_rdata1(buf_rdata1),
    .cmd_o(cmd), .req_tgl_o(req_tgl), .ack_tgl_i(ack_tgl),
    .rsp_data_i(rsp_data), .fwd_busy_o(fwd_busy)
  );

  mrb_usr_side #(.SYNC_STAGES(SYNC_STAGES)) u_usr (
    .clk(usr_clk), .rst_n(usr_rst_n),
    .req_tgl_i(req_tgl), .cmd_i(cmd),
    .reg_wr_en(reg_wr_en), .reg_rd_req(reg_rd_req),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_be(reg_be),
    .reg_rd_valid(reg_rd_valid), .reg_rd_data(reg_rd_data),
    .ack_tgl_o(ack_tgl), .rsp_data_o(rsp_data)
  );
endmodule

// File: rtl/mrb_checker.sv
module mrb_checker import mrb_pkg::*; (
  input logic              cpu_clk,
  input logic              cpu_rst_n,
  input logic              usr_clk,
  input logic              usr_rst_n,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic              cpu_rvalid,
  input logic              cpu_wait,
  input logic              fwd_busy,
  input logic [N_BUF-1:0]  buf_wr,
  input logic [N_BUF-1:0]  buf_rd,
  input logic              reg_wr_en,
  input logic              reg_rd_req,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [BE_W-1:0]   reg_be
);
  logic [3:0] rd_open;
  logic       rd_take;

  assign rd_take = cpu_rd && !cpu_wait;

  always_ff @(posedge cpu_clk or negedge cpu_rst_n) begin
    if (!cpu_rst_n) rd_open <= '0;
    else            rd_open <= rd_open + {3'd0, rd_take} - {3'd0, cpu_rvalid};
  end

  p_one_buf_r2: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    $onehot0({buf_wr, buf_rd}));

  p_buf_nowait_r6: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    (|{buf_wr, buf_rd}) |-> !cpu_wait);

  p_fwd_wait_r5: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    ((cpu_rd || cpu_wr) && !fwd_busy && !(|{buf_wr, buf_rd})) |-> cpu_wait);

  p_rvalid_has_read_r8: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    cpu_rvalid |-> (rd_open != 4'd0 || rd_take));

  p_one_strobe_r9: assert property (@(posedge usr_clk) disable iff (!usr_rst_n)
    $onehot0({reg_wr_en, reg_rd_req}));

  p_wr_pulse_r4: assert property (@(posedge usr_clk) disable iff (!usr_rst_n)
    reg_wr_en |=> !reg_wr_en);

  p_rdreq_pulse_r7: assert property (@(posedge usr_clk) disable iff (!usr_rst_n)
    reg_rd_req |=> !reg_rd_req);

  p_bundle_hold_r10: assert property (@(posedge usr_clk) disable iff (!usr_rst_n)
    (reg_wr_en || reg_rd_req) |=> $stable({reg_addr, reg_wdata, reg_be}));
endmodule

bind mm_reg_bridge mrb_checker u_chk (
  .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n),
  .usr_clk(usr_clk), .usr_rst_n(usr_rst_n),
  .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
  .cpu_rvalid(cpu_rvalid), .cpu_wait(cpu_wait), .fwd_busy(fwd_busy),
  .buf_wr(buf_wr), .buf_rd(buf_rd),
  .reg_wr_en(reg_wr_en), .reg_rd_req(reg_rd_req),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_be(reg_be)
);

// File: tb/mm_reg_bridge_tb.sv
`timescale 1ns/1ps
module mm_reg_bridge_tb;
  logic        cpu_clk = 0, usr_clk = 0;
  logic        cpu_rst_n = 0, usr_rst_n = 0;
  logic [13:0] cpu_addr = '0;
  logic        cpu_wr = 0, cpu_rd = 0;
  logic [31:0] cpu_wdata = '0;
  logic [3:0]  cpu_be = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_rvalid, cpu_wait;
  logic [1:0]  buf_wr, buf_rd;
  logic [8:0]  buf_addr;
  logic [31:0] buf_wdata, buf_rdata0, buf_rdata1;
  logic [3:0]  buf_be;
  logic        reg_wr_en, reg_rd_req, reg_rd_valid;
  logic [13:0] reg_addr;
  logic [31:0] reg_wdata, reg_rd_data;
  logic [3:0]  reg_be;

  always #10 cpu_clk = ~cpu_clk;
  always #18.5 usr_clk = ~usr_clk;

  mm_reg_bridge u_dut (.*);

  // buffer RAM models, two-cycle read latency
  logic [31:0] mem0 [512];
  logic [31:0] mem1 [512];
  logic [31:0] s1_0, s2_0, s1_1, s2_1;
  always @(posedge cpu_clk) begin
    for (int b = 0; b < 4; b++) begin
      if (buf_wr[0] && buf_be[b]) mem0[buf_addr][8*b +: 8] <= buf_wdata[8*b +: 8];
      if (buf_wr[1] && buf_be[b]) mem1[buf_addr][8*b +: 8] <= buf_wdata[8*b +: 8];
    end
    s1_0 <= mem0[buf_addr]; s2_0 <= s1_0;
    s1_1 <= mem1[buf_addr]; s2_1 <= s1_1;
  end
  assign buf_rdata0 = s2_0;
  assign buf_rdata1 = s2_1;

  // user register file model
  logic [31:0] uregs [16];
  logic [13:0] pend_addr, last_wr_addr, last_rd_addr;
  logic [1:0]  cd;
  int          wr_cnt = 0, rdq_cnt = 0;
  initial for (int i = 0; i < 16; i++) uregs[i] = 32'hA000_0000 | i;
  always @(posedge usr_clk or negedge usr_rst_n) begin
    if (!usr_rst_n) begin
      cd <= 0; reg_rd_valid <= 0; reg_rd_data <= '0;
    end else begin
      reg_rd_valid <= 0;
      if (reg_wr_en) begin
        for (int b = 0; b < 4; b++)
          if (reg_be[b]) uregs[reg_addr[3:0]][8*b +: 8] <= reg_wdata[8*b +: 8];
        last_wr_addr <= reg_addr;
        wr_cnt <= wr_cnt + 1;
      end
      if (reg_rd_req) begin
        pend_addr <= reg_addr; last_rd_addr <= reg_addr;
        rdq_cnt <= rdq_cnt + 1; cd <= 2;
      end else if (cd != 0) begin
        cd <= cd - 1;
        if (cd == 1) begin
          reg_rd_valid <= 1; reg_rd_data <= uregs[pend_addr[3:0]];
        end
      end
    end
  end

  int n_cmp = 0, n_bad = 0, rdv_on_wr = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [13:0] a, input logic [31:0] d, input logic [3:0] be,
                       output int waits);
    @(negedge cpu_clk);
    cpu_addr = a; cpu_wdata = d; cpu_be = be; cpu_wr = 1;
    #1; waits = 0;
    while (cpu_wait && waits < 500) begin
      if (cpu_rvalid) rdv_on_wr++;
      @(negedge cpu_clk); #1; waits++;
    end
    if (cpu_rvalid) rdv_on_wr++;
    @(negedge cpu_clk); cpu_wr = 0;
    repeat (3) begin #1; if (cpu_rvalid) rdv_on_wr++; @(negedge cpu_clk); end
  endtask

  task automatic do_rd(input logic [13:0] a, output logic [31:0] d,
                       output int waits, output int lat);
    bit got;
    @(negedge cpu_clk);
    cpu_addr = a; cpu_rd = 1;
    #1; waits = 0; got = 0; lat = 0; d = 'x;
    while (cpu_wait && waits < 500) begin @(negedge cpu_clk); #1; waits++; end
    if (cpu_rvalid) begin d = cpu_rdata; got = 1; end
    @(negedge cpu_clk); cpu_rd = 0;
    while (!got && lat < 20) begin
      lat++; #1;
      if (cpu_rvalid) begin d = cpu_rdata; got = 1; end
      else @(negedge cpu_clk);
    end
  endtask

  // op(1: read) | addr | data-or-expected | byte enables
  localparam int NV = 12;
  localparam logic [50:0] VEC [NV] = '{
    {1'b0, 14'h0005, 32'h1122_3344, 4'hF},
    {1'b1, 14'h0005, 32'h1122_3344, 4'hF},
    {1'b0, 14'h0005, 32'hAABB_CCDD, 4'h5},
    {1'b1, 14'h0005, 32'h11BB_33DD, 4'hF},
    {1'b0, 14'h0203, 32'hCAFE_F00D, 4'hF},
    {1'b1, 14'h0203, 32'hCAFE_F00D, 4'hF},
    {1'b0, 14'h05FF, 32'h0BAD_BEEF, 4'hF},
    {1'b1, 14'h05FF, 32'h0BAD_BEEF, 4'hF},
    {1'b0, 14'h0600, 32'h55AA_55AA, 4'hF},
    {1'b1, 14'h0600, 32'h55AA_55AA, 4'hF},
    {1'b1, 14'h3FFF, 32'hA000_000F, 4'hF},
    {1'b1, 14'h0203, 32'hCAFE_F00D, 4'hF}
  };

  initial begin
    int w, l;
    logic [31:0] d;
    bit is_buf;
    #5;
    @(negedge cpu_clk);
    chk("R1 reset wait/rvalid", {30'd0, cpu_wait, cpu_rvalid}, 32'd0);
    chk("R1 reset strobes", {30'd0, reg_wr_en, reg_rd_req}, 32'd0);
    repeat (3) @(negedge cpu_clk);
    cpu_rst_n = 1; usr_rst_n = 1;
    repeat (3) @(negedge cpu_clk);

    for (int i = 0; i < NV; i++) begin
      is_buf = (VEC[i][49:45] == 5'd1) || (VEC[i][49:45] == 5'd2);
      if (VEC[i][50]) begin
        do_rd(VEC[i][49:36], d, w, l);
        chk($sformatf("R2 R3 R4 read data vec%0d", i), d, VEC[i][35:4]);
        if (is_buf) begin
          chk($sformatf("R6 buffer wait vec%0d", i), w, 0);
          chk($sformatf("R6 buffer latency vec%0d", i), l, 2);
        end else begin
          chk($sformatf("R7 same-cycle return vec%0d", i), l, 0);
          chk($sformatf("R5 held wait vec%0d", i), 32'(w >= 6), 1);
        end
      end else begin
        do_wr(VEC[i][49:36], VEC[i][35:4], VEC[i][3:0], w);
        if (is_buf) chk($sformatf("R6 buffer write wait vec%0d", i), w, 0);
        else        chk($sformatf("R5 write held wait vec%0d", i), 32'(w >= 4), 1);
      end
    end

    repeat (10) @(negedge cpu_clk);
    chk("R2 R4 forwarded write count", wr_cnt, 3);
    chk("R2 R7 forwarded read count", rdq_cnt, 4);
    chk("R3 last write address", {18'd0, last_wr_addr}, 32'h0600);
    chk("R3 last read address", {18'd0, last_rd_addr}, 32'h3FFF);
    chk("R8 no rvalid on writes", rdv_on_wr, 0);

    // R1: drop both resets during a forwarded read, then recover
    @(negedge cpu_clk);
    cpu_addr = 14'h0005; cpu_rd = 1;
    repeat (3) @(negedge cpu_clk);
    cpu_rst_n = 0; usr_rst_n = 0; cpu_rd = 0;
    repeat (4) @(negedge cpu_clk);
    #1;
    chk("R1 mid-flight reset wait", {31'd0, cpu_wait}, 32'd0);
    chk("R1 mid-flight reset rvalid", {31'd0, cpu_rvalid}, 32'd0);
    cpu_rst_n = 1; usr_rst_n = 1;
    repeat (4) @(negedge cpu_clk);
    do_rd(14'h0005, d, w, l);
    chk("R1 R9 read after reset", d, 32'h11BB_33DD);
    do_wr(14'h0007, 32'h0F0F_0F0F, 4'hA, w);
    do_rd(14'h0007, d, w, l);
    chk("R4 upper-byte merge", d, 32'h0F00_0F07);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R5 actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule